// File: doc/BRIEF.md
# Flat-Panel Image Expander

This block takes a pixel stream from the display pipeline and turns it into a stream sized for a digital flat panel. The source image is usually smaller than the panel. The block stretches it along each axis by a ratio: after every K source items it adds J more. In text mode the added pixels and lines are blank. In graphics mode each added pixel repeats the source pixel before it, and each added line replays the line just emitted. A single line buffer holds that line. With stretching turned off, or when the stretched image is still too small, the rest of the panel is filled with blank pixels. Parts of the stretched image that fall outside the panel are dropped.

The source arrives on a valid/ready handshake. Each pixel carries frame-start, line-end and frame-end markers. The block emits at most one panel pixel per cycle. Each pixel comes with a data-enable, a line marker on the first pixel of every panel line and a frame marker on the first pixel of the frame. Panel size, the two J/K pairs and the mode come from configuration inputs. These are captured only when a frame starts.

Top module: `fpx_expander`

## Requirements
- R1: After reset, out_de, out_hs and out_vs are low. While no frame is in progress, in_ready is high as long as in_sof is low.
- R2: Every frame produces exactly H lines of exactly W pixels, in raster order. H and W are the captured cfg_height and cfg_width, each clamped to 1..1024. out_hs is high on the first pixel of each line. out_vs is high only on the first pixel of the frame.
- R3: Expansion is off on an axis when its add count J or its period K is 0. With horizontal expansion off, source pixels appear in order and are then padded with zero pixels up to W. With vertical expansion off, source lines appear in order and are then padded with all-zero lines up to H.
- R4: In graphics mode (cfg_graphics=1), every K-th accepted source pixel of a line is followed by J copies of that pixel. Pixel counting restarts at each line.
- R5: In text mode (cfg_graphics=0), every K-th source pixel of a line is followed by J pixels of value 0.
- R6: In graphics mode, every K-th source line is followed by J replays of that line as it was emitted to the panel, including its horizontal expansion and padding.
- R7: In text mode, every K-th source line is followed by J lines of value 0.
- R8: Expanded pixels beyond W and lines beyond H are dropped. Source pixels beyond the panel are still accepted and discarded, up to the pixel marked in_eof.
- R9: A pixel transfers when in_valid and in_ready are both high. in_ready stays low while added pixels or added lines are being emitted. No pixel is lost.
- R10: Configuration inputs are captured when a frame-start pixel is offered while idle. Changes made during a frame have no effect until the next frame.
- R11: A pixel offered while idle without in_sof is accepted and discarded, and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_width | input | 11 | Panel width in pixels, 1..1024 |
| cfg_height | input | 11 | Panel height in lines, 1..1024 |
| cfg_h_add | input | 4 | Horizontal J: pixels added per group |
| cfg_h_every | input | 4 | Horizontal K: source pixels per group |
| cfg_v_add | input | 4 | Vertical J: lines added per group |
| cfg_v_every | input | 4 | Vertical K: source lines per group |
| cfg_graphics | input | 1 | 1 = graphics (replicate), 0 = text (blank) |
| in_valid | input | 1 | Source pixel valid |
| in_ready | output | 1 | Block accepts the source pixel |
| in_data | input | 24 | Source pixel value |
| in_sof | input | 1 | First pixel of a source frame |
| in_eol | input | 1 | Last pixel of a source line |
| in_eof | input | 1 | Last pixel of a source frame |
| out_de | output | 1 | Panel pixel valid |
| out_hs | output | 1 | First pixel of a panel line |
| out_vs | output | 1 | First pixel of a panel frame |
| out_data | output | 24 | Panel pixel value |

## Verification
Some properties are checked by assertions on every cycle. These are: in_ready stays low whenever a non-source line or a pending added pixel is in flight, pixels are emitted only inside the panel, captured settings stay frozen for the whole frame, added pixels and lines in text mode come out as zero, and a completed group loads exactly J added items. Other behaviour can only be shown by the bench's frame scenarios, each compared pixel by pixel against a queue-based model. That covers the order and content of replicated pixels and replayed lines, padding and clipping at the panel edges, draining of an oversized source, discarding of stray pixels, and the one-frame delay before new settings apply.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int RATIO_W = 4;
  typedef logic [RATIO_W-1:0] ratio_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} fpx_state_e;
  typedef enum logic [2:0] {LN_SRC, LN_REP, LN_PAD, LN_EOL, LN_PICK} fpx_line_e;

  // Clamp a programmed panel dimension into 1..mx.
  function automatic int clamp_dim(int v, int mx);
    if (v < 1) return 1;
    if (v > mx) return mx;
    return v;
  endfunction

  // True when the item being counted closes a group of k and j items follow.
  function automatic logic group_done(ratio_t cnt, ratio_t j, ratio_t k);
    return (k != '0) && (j != '0) && (({1'b0, cnt} + 1'b1) == {1'b0, k});
  endfunction
endpackage

// File: rtl/fpx_ratio_ctr.sv
module fpx_ratio_ctr
  import fpx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   step,
  input  logic   take,
  input  ratio_t add_j,
  input  ratio_t every_k,
  output logic   fire,
  output logic   pend
);
  ratio_t cnt_q;
  ratio_t rem_q;

  assign fire = step && group_done(cnt_q, add_j, every_k);
  assign pend = (rem_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rem_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      rem_q <= '0;
    end else begin
      if (step) cnt_q <= fire ? '0 : cnt_q + 1'b1;
      if (fire) rem_q <= add_j;
      else if (take && pend) rem_q <= rem_q - 1'b1;
    end
  end

  AST_GROUP_LOADS_J: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !clr |=> rem_q == $past(add_j)); // R4
  AST_TAKE_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend); // R9
endmodule

// File: rtl/fpx_line_buf.sv
module fpx_line_buf #(
  parameter  int PIX_W = 24,
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [PIX_W-1:0] rdata
);
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fpx_out_stage.sv
module fpx_out_stage #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de_d,
  input  logic             hs_d,
  input  logic             vs_d,
  input  logic [PIX_W-1:0] data_d,
  output logic             de_q,
  output logic             hs_q,
  output logic             vs_q,
  output logic [PIX_W-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q   <= 1'b0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      data_q <= '0;
    end else begin
      de_q   <= de_d;
      hs_q   <= hs_d;
      vs_q   <= vs_d;
      data_q <= de_d ? data_d : '0;
    end
  end
endmodule

// File: rtl/fpx_expander.sv
module fpx_expander
  import fpx_pkg::*;
#(
  parameter  int PIX_W   = 24,
  parameter  int MAX_DIM = 1024,
  localparam int DIM_W   = $clog2(MAX_DIM + 1),
  localparam int AW      = $clog2(MAX_DIM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIM_W-1:0]   cfg_width,
  input  logic [DIM_W-1:0]   cfg_height,
  input  logic [RATIO_W-1:0] cfg_h_add,
  input  logic [RATIO_W-1:0] cfg_h_every,
  input  logic [RATIO_W-1:0] cfg_v_add,
  input  logic [RATIO_W-1:0] cfg_v_every,
  input  logic               cfg_graphics,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [PIX_W-1:0]   in_data,
  input  logic               in_sof,
  input  logic               in_eol,
  input  logic               in_eof,
  output logic               out_de,
  output logic               out_hs,
  output logic               out_vs,
  output logic [PIX_W-1:0]   out_data
);
  // captured frame settings
  logic [DIM_W-1:0] w_q, h_q;
  ratio_t           hj_q, hk_q, vj_q, vk_q;
  logic             gfx_q;

  // raster state
  fpx_state_e       st_q, st_d;
  fpx_line_e        lt_q, lt_d;
  logic [DIM_W-1:0] ox_q, ox_d, oy_q, oy_d;
  logic             line_done_q, line_done_d;
  logic             frame_done_q, frame_done_d;
  logic [PIX_W-1:0] hold_q, hold_d;

  // named internal events
  logic             emit, buf_we, latch_cfg, x_room;
  logic [PIX_W-1:0] emit_data, buf_rdata;
  logic             h_step, h_take, h_clr, h_fire, h_pend;
  logic             v_step, v_take, v_clr, v_fire, v_pend;

  assign x_room = (ox_q < w_q);

  fpx_ratio_ctr u_hratio (
    .clk(clk), .rst_n(rst_n), .clr(h_clr), .step(h_step), .take(h_take),
    .add_j(hj_q), .every_k(hk_q), .fire(h_fire), .pend(h_pend)
  );

  fpx_ratio_ctr u_vratio (
    .clk(clk), .rst_n(rst_n), .clr(v_clr), .step(v_step), .take(v_take),
    .add_j(vj_q), .every_k(vk_q), .fire(v_fire), .pend(v_pend)
  );

  fpx_line_buf #(.PIX_W(PIX_W), .DEPTH(MAX_DIM)) u_lbuf (
    .clk(clk), .we(buf_we), .waddr(ox_q[AW-1:0]), .wdata(emit_data),
    .raddr(ox_q[AW-1:0]), .rdata(buf_rdata)
  );

  always_comb begin
    emit = 1'b0; emit_data = '0; buf_we = 1'b0; in_ready = 1'b0; latch_cfg = 1'b0;
    h_step = 1'b0; h_take = 1'b0; h_clr = 1'b0;
    v_step = 1'b0; v_take = 1'b0; v_clr = 1'b0;
    st_d = st_q; lt_d = lt_q; ox_d = ox_q; oy_d = oy_q;
    line_done_d = line_done_q; frame_done_d = frame_done_q; hold_d = hold_q;
    unique case (st_q)
      ST_IDLE: begin
        in_ready = !in_sof;
        if (in_valid && in_sof) begin
          latch_cfg = 1'b1;
          st_d = ST_RUN; lt_d = LN_SRC;
          ox_d = '0; oy_d = '0;
          line_done_d = 1'b0; frame_done_d = 1'b0;
          h_clr = 1'b1; v_clr = 1'b1;
        end
      end
      ST_DRAIN: begin
        in_ready = 1'b1;
        if (in_valid && in_eof) st_d = ST_IDLE;
      end
      default: begin
        unique case (lt_q)
          LN_SRC: begin
            if (h_pend) begin
              if (x_room) begin
                emit = 1'b1; emit_data = hold_q; buf_we = 1'b1; h_take = 1'b1;
                ox_d = ox_q + 1'b1;
              end else begin
                h_clr = 1'b1;
              end
            end else if (!line_done_q) begin
              in_ready = 1'b1;
              if (in_valid) begin
                h_step = 1'b1;
                if (x_room) begin
                  emit = 1'b1; emit_data = in_data; buf_we = 1'b1;
                  ox_d = ox_q + 1'b1;
                end
                if (h_fire) hold_d = gfx_q ? in_data : '0;
                if (in_eol || in_eof) line_done_d = 1'b1;
                if (in_eof) frame_done_d = 1'b1;
              end
            end else if (x_room) begin
              emit = 1'b1; buf_we = 1'b1;
              ox_d = ox_q + 1'b1;
            end else begin
              v_step = 1'b1;
              lt_d = LN_EOL;
            end
          end
          LN_REP, LN_PAD: begin
            if (x_room) begin
              emit = 1'b1;
              emit_data = (lt_q == LN_REP && gfx_q) ? buf_rdata : '0;
              ox_d = ox_q + 1'b1;
            end else begin
              lt_d = LN_EOL;
            end
          end
          LN_EOL: begin
            ox_d = '0; h_clr = 1'b1; line_done_d = 1'b0;
            if (oy_q == h_q - 1'b1) st_d = frame_done_q ? ST_IDLE : ST_DRAIN;
            else begin
              oy_d = oy_q + 1'b1;
              lt_d = LN_PICK;
            end
          end
          default: begin
            if (v_pend) begin
              v_take = 1'b1;
              lt_d = LN_REP;
            end else begin
              lt_d = frame_done_q ? LN_PAD : LN_SRC;
            end
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; lt_q <= LN_SRC;
      ox_q <= '0; oy_q <= '0;
      line_done_q <= 1'b0; frame_done_q <= 1'b0; hold_q <= '0;
      w_q <= DIM_W'(1); h_q <= DIM_W'(1);
      hj_q <= '0; hk_q <= '0; vj_q <= '0; vk_q <= '0; gfx_q <= 1'b0;
    end else begin
      st_q <= st_d; lt_q <= lt_d;
      ox_q <= ox_d; oy_q <= oy_d;
      line_done_q <= line_done_d; frame_done_q <= frame_done_d; hold_q <= hold_d;
      if (latch_cfg) begin
        w_q   <= DIM_W'(clamp_dim(int'(cfg_width), MAX_DIM));
        h_q   <= DIM_W'(clamp_dim(int'(cfg_height), MAX_DIM));
        hj_q  <= cfg_h_add;  hk_q <= cfg_h_every;
        vj_q  <= cfg_v_add;  vk_q <= cfg_v_every;
        gfx_q <= cfg_graphics;
      end
    end
  end

  fpx_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .de_d(emit), .hs_d(emit && ox_q == '0), .vs_d(emit && ox_q == '0 && oy_q == '0),
    .data_d(emit_data),
    .de_q(out_de), .hs_q(out_hs), .vs_q(out_vs), .data_q(out_data)
  );

  AST_EMIT_INSIDE_PANEL: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (ox_q < w_q) && (oy_q < h_q)); // R2
  AST_VS_ON_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    out_vs |-> out_hs && out_de); // R2
  AST_NO_ACCEPT_DURING_ADDED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) && (lt_q != LN_SRC || h_pend) |-> !in_ready); // R9
  AST_CFG_FROZEN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) && ($past(st_q) != ST_IDLE)
      |-> $stable(w_q) && $stable(h_q) && $stable(gfx_q) && $stable(hj_q) && $stable(vj_q)); // R10
  AST_TEXT_ADDED_LINE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    emit && !gfx_q && lt_q == LN_REP |=> out_de && out_data == '0); // R7
  AST_TEXT_ADDED_PIXEL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    emit && !gfx_q && h_take |=> out_de && out_data == '0); // R5
  AST_VGROUP_ON_SOURCE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    v_fire |-> lt_q == LN_SRC && st_q == ST_RUN); // R6
endmodule

// File: tb/fpx_expander_tb.sv
`timescale 1ns/1ps
module fpx_expander_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] p_w = 11'd1, p_h = 11'd1;
  logic [3:0]  p_hj = '0, p_hk = '0, p_vj = '0, p_vk = '0;
  logic        p_gfx = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, in_eof = 1'b0;
  logic [23:0] in_data = '0;
  logic        in_ready, out_de, out_hs, out_vs;
  logic [23:0] out_data;

  always #4 clk = ~clk;

  fpx_expander u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_width(p_w), .cfg_height(p_h),
    .cfg_h_add(p_hj), .cfg_h_every(p_hk), .cfg_v_add(p_vj), .cfg_v_every(p_vk),
    .cfg_graphics(p_gfx),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eol(in_eol), .in_eof(in_eof),
    .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs), .out_data(out_data)
  );

  int n_tests = 0, n_fail = 0;
  int c_w, c_h, c_hj, c_hk, c_vj, c_vk, c_gfx;
  int a_w, a_h, a_hj, a_hk, a_vj, a_vk, a_gfx;
  int eq_data[$];
  bit eq_hs[$], eq_vs[$], eq_ext[$];
  int mis = 0, mis_act = 0, mis_exp = 0, extra_out = 0, out_cnt = 0, ext_viol = 0;
  int acc_total = 0, cycles = 0;
  bit acc_q = 1'b0, last_rdy = 1'b0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pix(int f, int y, int x);
    return ((f * 7919 + y * 257 + x * 13) & 32'h00FFFFFE) | 1;
  endfunction

  always @(posedge clk) begin
    acc_q <= in_valid && in_ready;
    if (in_valid && in_ready) acc_total <= acc_total + 1;
    cycles <= cycles + 1;
  end

  always @(posedge clk) begin
    if (cycles > 190000) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 190000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // output monitor, sampled after the falling edge
  always begin
    @(negedge clk);
    #1;
    if (rst_n && out_de) begin
      out_cnt++;
      if (eq_data.size() == 0) extra_out++;
      else begin
        int d;
        bit h, v, e;
        d = eq_data.pop_front(); h = eq_hs.pop_front(); v = eq_vs.pop_front(); e = eq_ext.pop_front();
        if (out_data !== d[23:0] || out_hs !== h || out_vs !== v) begin
          if (mis == 0) begin mis_act = int'(out_data); mis_exp = d; end
          mis++;
        end
        if (e && last_rdy) ext_viol++; // R9: no acceptance while an added item was emitted
      end
    end
    last_rdy = in_ready;
  end

  task automatic set_cfg(int w, int h, int hj, int hk, int vj, int vk, int g);
    c_w = w; c_h = h; c_hj = hj; c_hk = hk; c_vj = vj; c_vk = vk; c_gfx = g;
    p_w = 11'(w); p_h = 11'(h); p_hj = 4'(hj); p_hk = 4'(hk);
    p_vj = 4'(vj); p_vk = 4'(vk); p_gfx = g[0];
  endtask

  task automatic push_line(int line[$], bit lext[$], bit first, bit blank, bit added);
    for (int i = 0; i < c_w; i++) begin
      eq_data.push_back(blank ? 0 : line[i]);
      eq_hs.push_back(i == 0);
      eq_vs.push_back(first && i == 0);
      eq_ext.push_back(added ? 1'b1 : lext[i]);
    end
  endtask

  // reference model of one panel frame from the requirements
  task automatic build_expected(int f, int sw, int sh);
    int line[$];
    bit lext[$];
    int ny = 0;
    for (int y = 0; y < sh && ny < c_h; y++) begin
      line.delete(); lext.delete();
      for (int x = 0; x < sw; x++) begin
        line.push_back(pix(f, y, x)); lext.push_back(1'b0);
        if (c_hk != 0 && c_hj != 0 && (x + 1) % c_hk == 0)
          for (int r = 0; r < c_hj; r++) begin
            line.push_back(c_gfx != 0 ? pix(f, y, x) : 0);
            lext.push_back(1'b1);
          end
      end
      while (line.size() < c_w) begin line.push_back(0); lext.push_back(1'b0); end
      push_line(line, lext, ny == 0, 1'b0, 1'b0);
      ny++;
      if (c_vk != 0 && c_vj != 0 && (y + 1) % c_vk == 0)
        for (int r = 0; r < c_vj && ny < c_h; r++) begin
          push_line(line, lext, 1'b0, c_gfx == 0, 1'b1);
          ny++;
        end
    end
    line.delete(); lext.delete();
    for (int i = 0; i < c_w; i++) begin line.push_back(0); lext.push_back(1'b0); end
    while (ny < c_h) begin
      push_line(line, lext, ny == 0, 1'b1, 1'b0);
      ny++;
    end
  endtask

  task automatic drive_frame(int f, int sw, int sh, int stall, bit mid_change);
    for (int y = 0; y < sh; y++)
      for (int x = 0; x < sw; x++) begin
        in_data = 24'(pix(f, y, x));
        in_sof = (x == 0 && y == 0);
        in_eol = (x == sw - 1);
        in_eof = (x == sw - 1 && y == sh - 1);
        in_valid = 1'b1;
        @(negedge clk);
        while (!acc_q) @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0; in_eof = 1'b0;
        if (mid_change && x == 0 && y == 0) begin
          p_w = 11'(a_w); p_h = 11'(a_h); p_hj = 4'(a_hj); p_hk = 4'(a_hk);
          p_vj = 4'(a_vj); p_vk = 4'(a_vk); p_gfx = a_gfx[0];
        end
        if (stall != 0 && (x + y) % stall == 0) @(negedge clk);
      end
  endtask

  task automatic run_frame(int f, int sw, int sh, int stall, bit mid_change, string req);
    int exp_n;
    int acc0;
    int t;
    build_expected(f, sw, sh);
    exp_n = eq_data.size();
    mis = 0; extra_out = 0; out_cnt = 0; acc0 = acc_total;
    drive_frame(f, sw, sh, stall, mid_change);
    t = 0;
    while (eq_data.size() != 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    check(mis == 0 && extra_out == 0, req, "pixel stream value", mis_act, mis_exp);
    check(out_cnt == exp_n, req, "pixel count", out_cnt, exp_n);
    check(acc_total - acc0 == sw * sh, "R9", "source pixels accepted", acc_total - acc0, sw * sh);
    eq_data.delete(); eq_hs.delete(); eq_vs.delete(); eq_ext.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check(out_de == 1'b0 && out_hs == 1'b0 && out_vs == 1'b0, "R1", "outputs idle after reset",
          {out_de, out_hs, out_vs}, 0);
    check(in_ready == 1'b1, "R1", "ready while idle", in_ready, 1);
    @(negedge clk);

    // R3 horizontal off through J=0, vertical off, graphics, padding both ways
    set_cfg(20, 12, 0, 3, 0, 0, 1);
    run_frame(1, 12, 8, 0, 1'b0, "R3");
    // R3 horizontal off through K=0, text
    set_cfg(14, 9, 2, 0, 3, 0, 0);
    run_frame(2, 10, 6, 3, 1'b0, "R3");
    // R4 graphics horizontal replication with stalls
    set_cfg(30, 8, 1, 2, 0, 0, 1);
    run_frame(3, 16, 8, 4, 1'b0, "R4");
    // R5 text horizontal blank insertion
    set_cfg(24, 6, 2, 3, 0, 0, 0);
    run_frame(4, 12, 6, 0, 1'b0, "R5");
    // R6 graphics line doubling combined with horizontal stretch clipped (R8)
    set_cfg(16, 20, 3, 4, 1, 1, 1);
    run_frame(5, 16, 10, 5, 1'b0, "R6");
    // R7 text blank lines, then padded height
    set_cfg(18, 18, 1, 5, 2, 3, 0);
    run_frame(6, 10, 9, 0, 1'b0, "R7");
    // R8 oversized source is clipped and drained
    set_cfg(8, 5, 1, 1, 1, 2, 1);
    run_frame(7, 20, 12, 0, 1'b0, "R8");
    // R10 mid-frame change ignored, applied on the following frame
    set_cfg(12, 6, 1, 1, 0, 0, 1);
    a_w = 10; a_h = 8; a_hj = 0; a_hk = 0; a_vj = 1; a_vk = 1; a_gfx = 0;
    run_frame(8, 8, 5, 0, 1'b1, "R10");
    set_cfg(a_w, a_h, a_hj, a_hk, a_vj, a_vk, a_gfx);
    run_frame(9, 8, 5, 0, 1'b0, "R10");
    // R11 stray pixels outside a frame are dropped
    begin
      int acc0;
      out_cnt = 0; extra_out = 0;
      acc0 = acc_total;
      for (int i = 0; i < 5; i++) begin
        in_data = 24'(pix(99, 0, i)); in_valid = 1'b1;
        @(negedge clk);
        while (!acc_q) @(negedge clk);
        in_valid = 1'b0;
      end
      repeat (4) @(negedge clk);
      check(acc_total - acc0 == 5, "R11", "stray pixels accepted", acc_total - acc0, 5);
      check(out_cnt == 0, "R11", "stray pixels produce no output", out_cnt, 0);
    end
    set_cfg(9, 4, 0, 0, 0, 0, 1);
    run_frame(10, 9, 4, 0, 1'b0, "R11");
    // R2 full panel width exercises the top of the line buffer, with replay (R6)
    set_cfg(1024, 4, 1, 1, 1, 2, 1);
    run_frame(11, 600, 2, 0, 1'b0, "R2");
    // R2 smallest panel
    set_cfg(1, 1, 0, 0, 0, 0, 0);
    run_frame(12, 3, 3, 0, 1'b0, "R2");
    // R8 largest ratio fields clip added lines at the panel bottom
    set_cfg(64, 4, 15, 15, 15, 1, 1);
    run_frame(13, 40, 2, 0, 1'b0, "R8");

    check(ext_viol == 0, "R9", "ready low during added items", ext_viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule